// File: doc/BRIEF.md
# Runtime-Programmable Sum-of-Products Array

This block evaluates a set of sum-of-products functions over a small input word. It offers every input to a product plane twice, once as is and once inverted. Each of the N product lines is the AND of whichever of those literals its row enables. A product line can use a single literal, a full minterm or anything in between. An OR plane then builds each of the P outputs from any subset of the shared product lines, so one product can feed several outputs. The path from `in_vec` to `out_vec` has no register in it.

The connection bits sit in flip-flops that a synchronous configuration port loads one product row per write. Each row holds 2·M literal-enable bits and P output-connect bits. A combinational readback port returns the stored bits of any row. The port applies no back-pressure and has no ready signal: every strobed write to a valid row is accepted at the next rising edge. A write to an index at or beyond N is dropped. The input and output words are plain level signals and have no handshake. The array is meant for small decode and glue functions whose equations software chooses at run time, and N is normally much smaller than 2^M.

Top module: `sop_array`

## Requirements
- R1: Product line n is the AND of the literals its row enables. In the row's literal-enable field, bit k (k < M) enables input bit k in true form, and bit M+k enables input bit k in complemented form.
- R2: A product row with no literal enabled evaluates to 1.
- R3: A product row that enables both polarities of the same input evaluates to 0 for every input value.
- R4: Output p is the OR of the product lines whose output-connect bit p is set. One product line may drive several outputs at the same time.
- R5: An output with no product line connected is 0 for every input value.
- R6: While `cfg_we` is 1 on a rising edge, `cfg_and` and `cfg_or` are stored into row `cfg_row`. The stored bits show on the readback port only after that edge. The readback port presents row `rd_row` combinationally and returns zeros for an index at or beyond N.
- R7: A write whose `cfg_row` is at or beyond N changes no stored bit and no output.
- R8: While `rst` is 1 on a rising edge, all connection bits are cleared, which forces every output to 0.
- R9: `out_vec` follows a change of `in_vec` within the same cycle, with no clock edge needed.
- R10: With M=3 and inputs A, B, C on `in_vec` bits 2, 1, 0, the array can be loaded so that output bit 1 is A·B + (not B)·C and output bit 0 is A·B, using only two product rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous reset, active high; clears all connection bits |
| in_vec | input | M | Input word of the logic functions |
| out_vec | output | P | Sum-of-products results |
| cfg_we | input | 1 | Write strobe for one configuration row |
| cfg_row | input | RW | Index of the row to write |
| cfg_and | input | 2·M | Literal enables: bits M-1..0 true form, bits 2M-1..M complemented form |
| cfg_or | input | P | Output-connect bits, bit p to output p |
| rd_row | input | RW | Index of the row to read back |
| rd_and | output | 2·M | Stored literal enables of row `rd_row` |
| rd_or | output | P | Stored output-connect bits of row `rd_row` |

RW is clog2(N), with a minimum of 1.

## Verification
The assertions take for granted that `rst` is held for at least one rising edge before the first configuration write. They also take for granted that `cfg_we`, `cfg_row` and the data fields are stable around each rising edge. The bench meets both conditions by asserting reset for several cycles and changing every input only on falling edges. The no-state check assumes that `in_vec` moves only between edges. The bench changes it on falling edges, or with a small delay after them, and samples outputs one time unit later. An out-of-range write is exercised with the default N of 3, because a power-of-two N leaves no spare index to reach.

// File: rtl/sop_pkg.sv
package sop_pkg;
  // Width of a row index; never zero so single-row arrays still have a port.
  function automatic int row_bits(input int rows);
    return (rows > 1) ? $clog2(rows) : 1;
  endfunction
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int M  = 3,
  parameter int N  = 3,
  parameter int P  = 2,
  parameter int RW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [RW-1:0]    wr_row,
  input  logic [2*M-1:0]   wr_lit,
  input  logic [P-1:0]     wr_col,
  input  logic [RW-1:0]    rd_row,
  output logic [2*M-1:0]   rd_lit,
  output logic [P-1:0]     rd_col,
  output logic [N*2*M-1:0] lit_mat,
  output logic [N*P-1:0]   col_mat
);
  localparam int LW = 2 * M;

  for (genvar n = 0; n < N; n++) begin : g_row
    logic hit;
    assign hit = wr_en && (int'(wr_row) == n);
    always_ff @(posedge clk) begin
      if (rst) begin
        lit_mat[n*LW +: LW] <= '0;
        col_mat[n*P +: P]   <= '0;
      end else if (hit) begin
        lit_mat[n*LW +: LW] <= wr_lit;
        col_mat[n*P +: P]   <= wr_col;
      end
    end
  end

  always_comb begin
    rd_lit = '0;
    rd_col = '0;
    for (int n = 0; n < N; n++) begin
      if (int'(rd_row) == n) begin
        rd_lit = lit_mat[n*LW +: LW];
        rd_col = col_mat[n*P +: P];
      end
    end
  end
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int M = 3,
  parameter int N = 3
) (
  input  logic [M-1:0]     in_vec,
  input  logic [N*2*M-1:0] lit_mat,
  output logic [N-1:0]     term_vec
);
  localparam int LW = 2 * M;
  logic [LW-1:0] lit;

  assign lit = {~in_vec, in_vec};

  // A term is false as soon as one enabled literal is false.
  for (genvar n = 0; n < N; n++) begin : g_term
    assign term_vec[n] = &(lit | ~lit_mat[n*LW +: LW]);
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N = 3,
  parameter int P = 2
) (
  input  logic [N-1:0]   term_vec,
  input  logic [N*P-1:0] col_mat,
  output logic [P-1:0]   out_vec
);
  for (genvar p = 0; p < P; p++) begin : g_out
    logic [N-1:0] sel;
    for (genvar n = 0; n < N; n++) begin : g_tap
      assign sel[n] = col_mat[n*P + p];
    end
    assign out_vec[p] = |(term_vec & sel);
  end
endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int M  = 3,
  parameter int N  = 3,
  parameter int P  = 2,
  parameter int RW = sop_pkg::row_bits(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [M-1:0]    in_vec,
  output logic [P-1:0]    out_vec,
  input  logic            cfg_we,
  input  logic [RW-1:0]   cfg_row,
  input  logic [2*M-1:0]  cfg_and,
  input  logic [P-1:0]    cfg_or,
  input  logic [RW-1:0]   rd_row,
  output logic [2*M-1:0]  rd_and,
  output logic [P-1:0]    rd_or
);
  logic [N*2*M-1:0] and_mat;
  logic [N*P-1:0]   or_mat;
  logic [N-1:0]     term_vec;

  sop_cfg_store #(.M(M), .N(N), .P(P), .RW(RW)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_row(cfg_row), .wr_lit(cfg_and), .wr_col(cfg_or),
    .rd_row(rd_row), .rd_lit(rd_and), .rd_col(rd_or),
    .lit_mat(and_mat), .col_mat(or_mat)
  );

  sop_and_plane #(.M(M), .N(N)) u_and (
    .in_vec(in_vec), .lit_mat(and_mat), .term_vec(term_vec)
  );

  sop_or_plane #(.N(N), .P(P)) u_or (
    .term_vec(term_vec), .col_mat(or_mat), .out_vec(out_vec)
  );
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
  parameter int M  = 3,
  parameter int N  = 3,
  parameter int P  = 2,
  parameter int RW = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [M-1:0]     in_vec,
  input logic [P-1:0]     out_vec,
  input logic             cfg_we,
  input logic [RW-1:0]    cfg_row,
  input logic [2*M-1:0]   cfg_and,
  input logic [P-1:0]     cfg_or,
  input logic [N*2*M-1:0] and_mat,
  input logic [N*P-1:0]   or_mat,
  input logic [N-1:0]     term_vec
);
  localparam int LW = 2 * M;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && int'(cfg_row) < N) |=>
      (and_mat[int'($past(cfg_row))*LW +: LW] == $past(cfg_and)
       && or_mat[int'($past(cfg_row))*P +: P] == $past(cfg_or))); // R6

  AST_BAD_ROW_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && int'(cfg_row) >= N) |=> ($stable(and_mat) && $stable(or_mat))); // R7

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (and_mat == '0 && or_mat == '0 && out_vec == '0)); // R8

  AST_OUT_NEEDS_TERM: assert property (@(posedge clk) disable iff (rst)
    (out_vec != '0) |-> (term_vec != '0)); // R4

  AST_OUT_NEEDS_COL: assert property (@(posedge clk) disable iff (rst)
    (out_vec != '0) |-> (or_mat != '0)); // R5

  AST_NO_HIDDEN_STATE: assert property (@(posedge clk) disable iff (rst)
    ($stable(in_vec) && $stable(and_mat) && $stable(or_mat)) |-> $stable(out_vec)); // R9
endmodule

bind sop_array sop_array_chk #(.M(M), .N(N), .P(P), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .in_vec(in_vec), .out_vec(out_vec),
  .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_and(cfg_and), .cfg_or(cfg_or),
  .and_mat(and_mat), .or_mat(or_mat), .term_vec(term_vec)
);

// File: tb/sim_sop_array.sv
module sim_sop_array;
  localparam int CLK_PERIOD = 10;
  localparam int M  = 3;
  localparam int N  = 3;
  localparam int P  = 2;
  localparam int RW = 2;
  localparam int LW = 2 * M;

  // {A,B,C, expected out[1:0]} for the reference load
  localparam logic [4:0] REF_VEC [0:7] = '{
    5'b000_00, 5'b001_10, 5'b010_00, 5'b011_00,
    5'b100_00, 5'b101_10, 5'b110_11, 5'b111_11
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [M-1:0]  in_vec = '0;
  logic [P-1:0]  out_vec;
  logic          cfg_we = 1'b0;
  logic [RW-1:0] cfg_row = '0;
  logic [LW-1:0] cfg_and = '0;
  logic [P-1:0]  cfg_or = '0;
  logic [RW-1:0] rd_row = '0;
  logic [LW-1:0] rd_and;
  logic [P-1:0]  rd_or;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] lfsr = 32'h1D2C_3B4A;
  logic [LW-1:0] m_and [N];
  logic [P-1:0]  m_or  [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  sop_array #(.M(M), .N(N), .P(P)) u0 (
    .clk(clk), .rst(rst), .in_vec(in_vec), .out_vec(out_vec),
    .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_and(cfg_and), .cfg_or(cfg_or),
    .rd_row(rd_row), .rd_and(rd_and), .rd_or(rd_or)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int row, input logic [LW-1:0] a, input logic [P-1:0] o);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = row[RW-1:0]; cfg_and = a; cfg_or = o;
    @(negedge clk);
    cfg_we = 1'b0;
    if (row < N) begin m_and[row] = a; m_or[row] = o; end
  endtask

  function automatic logic [P-1:0] model(input logic [M-1:0] x);
    logic [LW-1:0] lit;
    logic [P-1:0] y;
    lit = {~x, x};
    y = '0;
    for (int n = 0; n < N; n++) begin
      logic prod;
      prod = 1'b1;
      for (int k = 0; k < LW; k++) if (m_and[n][k] && !lit[k]) prod = 1'b0;
      for (int p = 0; p < P; p++) if (prod && m_or[n][p]) y[p] = 1'b1;
    end
    return y;
  endfunction

  task automatic sweep(input string tag);
    for (int v = 0; v < (1 << M); v++) begin
      in_vec = v[M-1:0];
      #1;
      check(tag, 32'(out_vec), 32'(model(v[M-1:0])));
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    for (int n = 0; n < N; n++) begin m_and[n] = '0; m_or[n] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Reset state: rows cleared, outputs zero
    for (int n = 0; n < N; n++) begin
      rd_row = n[RW-1:0]; #1;
      check("R8 reset readback", 32'({rd_and, rd_or}), 32'h0);
    end
    sweep("R8 reset outputs zero");

    // Reference load: row0 = A.B to both outputs, row1 = ~B.C to output 1
    cfg_write(0, 6'b000_110, 2'b11);
    cfg_write(1, 6'b010_001, 2'b10);
    for (int i = 0; i < 8; i++) begin
      in_vec = REF_VEC[i][4:2];
      #1;
      check("R10 reference table", 32'(out_vec), 32'(REF_VEC[i][1:0]));
    end
    // R1 and R4: single-literal row, shared product
    cfg_write(2, 6'b100_000, 2'b01);
    sweep("R1 R4 single literal plus shared term");

    // R6: write visible only after the edge
    rd_row = 2'd2;
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = 2'd2; cfg_and = 6'b000_001; cfg_or = 2'b10;
    #1;
    check("R6 readback before edge", 32'({rd_and, rd_or}), 32'({6'b100_000, 2'b01}));
    @(negedge clk);
    cfg_we = 1'b0;
    m_and[2] = 6'b000_001; m_or[2] = 2'b10;
    #1;
    check("R6 readback after edge", 32'({rd_and, rd_or}), 32'({6'b000_001, 2'b10}));
    rd_row = 2'd3; #1;
    check("R6 readback of index beyond N", 32'({rd_and, rd_or}), 32'h0);

    // R7: write to row 3 (beyond N=3) changes nothing
    cfg_write(3, 6'b111_111, 2'b11);
    for (int n = 0; n < N; n++) begin
      rd_row = n[RW-1:0]; #1;
      check("R7 rows untouched", 32'({rd_and, rd_or}), 32'({m_and[n], m_or[n]}));
    end
    sweep("R7 outputs untouched");

    // R2 and R5: only an empty row, wired to output 0
    cfg_write(0, '0, 2'b01);
    cfg_write(1, '0, 2'b00);
    cfg_write(2, '0, 2'b00);
    for (int v = 0; v < 8; v++) begin
      in_vec = v[2:0]; #1;
      check("R2 empty row is one", 32'(out_vec[0]), 32'h1);
      check("R5 unconnected output is zero", 32'(out_vec[1]), 32'h0);
    end

    // R3: both polarities of input bit 1
    cfg_write(0, 6'b010_010, 2'b11);
    for (int v = 0; v < 8; v++) begin
      in_vec = v[2:0]; #1;
      check("R3 contradictory row is zero", 32'(out_vec), 32'h0);
    end

    // R9: output moves without a clock edge
    cfg_write(0, 6'b000_001, 2'b10);
    @(posedge clk); #2;
    in_vec = 3'b000; #1;
    check("R9 combinational low", 32'(out_vec), 32'h0);
    in_vec = 3'b001; #1;
    check("R9 combinational high", 32'(out_vec), 32'h2);

    // Random loads against the model
    for (int r = 0; r < 20; r++) begin
      for (int n = 0; n < N; n++) begin
        lfsr = step(lfsr); lfsr = step(lfsr);
        cfg_write(n, lfsr[LW-1:0], lfsr[LW+P-1:LW]);
      end
      for (int n = 0; n < N; n++) begin
        rd_row = n[RW-1:0]; #1;
        check("R6 random readback", 32'({rd_and, rd_or}), 32'({m_and[n], m_or[n]}));
      end
      sweep("R1 R4 random load");
    end

    // R8: reset after a load clears everything
    cfg_write(0, '0, 2'b11);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int n = 0; n < N; n++) begin m_and[n] = '0; m_or[n] = '0; end
    for (int n = 0; n < N; n++) begin
      rd_row = n[RW-1:0]; #1;
      check("R8 reset clears row", 32'({rd_and, rd_or}), 32'h0);
    end
    sweep("R8 outputs after reset");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #(CLK_PERIOD * 100000);
    join_any
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule